// File: doc/BRIEF.md
# Sliding Search-Window Buffer Controller

This block keeps a motion-estimation search window on chip while macroblocks are coded left to right along a row. Each new macroblock's window overlaps most of the window before it. The controller therefore fetches from external frame memory only the pixels that are new, writes them into a pixel store held outside the block, and turns window-relative read coordinates into physical store addresses.

Requests leave on a valid/ready channel and carry a clamped frame coordinate. Responses come back in request order, one pixel per beat, with no back-pressure. The window spans `2*SR_H+MB_SIZE` columns by `2*SR_V+MB_SIZE` rows. A mode input, sampled when each macroblock starts, selects one of two configurations:

- **Two-reference mode.** Two banks are filled, one per reference frame. Columns are addressed circularly through a base pointer.
- **Low-power mode.** A single reference frame is kept in a band that spans the whole padded frame width. Rows wrap modulo the window height, so rows already fetched for the macroblock row above are reused.

Top module: `swin_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `win_ready`, `req_vld`, `wr_en` and `rd_vld` are 0.
- R2: After an accepted start, requests walk the load region in order: bank first (0 then 1), then rows, then columns, column fastest. The region covers columns 0..WIN_W-1 when `mb_col`=0, otherwise the rightmost MB_SIZE columns. It covers rows 0..WIN_H-1, except that in low-power mode with `mb_row`>0 it covers only the bottom MB_SIZE rows. Two-reference mode loads banks 0 and 1; low-power mode loads bank 0 only.
- R3: A request for window pixel (lx,ly) carries x = mb_col*MB_SIZE - SR_H + lx and y = mb_row*MB_SIZE - SR_V + ly, each clamped into 0..frame size-1.
- R4: A pending request keeps its coordinates and bank until `req_rdy` takes it.
- R5: In two-reference mode, the write address is bank*WIN_W*WIN_H + ly*WIN_W + ((lx + mb_col*MB_SIZE) mod WIN_W).
- R6: In low-power mode, only bank 0 is requested. The write address is ((mb_row*MB_SIZE + ly) mod WIN_H)*(frame width + 2*SR_H) + mb_col*MB_SIZE + lx.
- R7: `win_ready` falls on the cycle after a start is accepted and rises on the cycle after the last pixel of the load is written.
- R8: A read presented while `win_ready`=1 returns `rd_vld`=1 one cycle later, with the address that R5 or R6 gives for (rd_x,rd_y). A read presented while `win_ready`=0 is dropped.
- R9: In low-power mode, `rd_ref` has no effect on the read address.
- R10: A start pulse that arrives while a load is in progress is ignored.
- R11: `wr_data` equals `rsp_pix`. A response beat that arrives when no load is pending produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_lp | input | 1 | Configuration select, sampled at start: 1 = low-power single reference |
| mb_start | input | 1 | Start pulse for a new macroblock |
| mb_col | input | MBC_W | Macroblock column index |
| mb_row | input | MBR_W | Macroblock row index |
| win_ready | output | 1 | The window for the current macroblock is fully loaded |
| req_vld | output | 1 | Fetch request valid |
| req_rdy | input | 1 | Fetch request accepted |
| req_ref | output | 1 | Reference frame of the request |
| req_x | output | FX_W | Clamped frame column |
| req_y | output | FY_W | Clamped frame row |
| rsp_vld | input | 1 | Response pixel valid |
| rsp_pix | input | PIX_W | Response pixel |
| wr_en | output | 1 | Pixel store write enable |
| wr_addr | output | ADDR_W | Pixel store write address |
| wr_data | output | PIX_W | Pixel store write data |
| rd_en | input | 1 | Read request |
| rd_ref | input | 1 | Read reference frame |
| rd_x | input | WX_W | Window-relative column |
| rd_y | input | WY_W | Window-relative row |
| rd_vld | output | 1 | Read address valid |
| rd_addr | output | ADDR_W | Physical read address |

## Verification
The assertions assume the following of the environment:

- Macroblocks start in raster order, with the first column of each row starting fresh.
- Responses return in request order and never outnumber the accepted requests.
- Each low-power pass begins at row 0.

The stimulus stays within these assumptions. It walks every macroblock of a small frame in order, once per mode, and produces response beats only from the bench's own queue of accepted requests. Random `req_rdy` stalls and random response gaps vary the timing. The only deliberate departures are a stray start pulse during a load and a stray response beat while idle; both are cases the block must ignore.

// File: rtl/swin_pkg.sv
package swin_pkg;

    localparam int CW = 16;

    typedef logic [CW-1:0] crd_t;

    typedef struct packed {
        crd_t first;
        crd_t last;
    } span_t;

    typedef struct packed {
        logic bank;
        crd_t lx;
        crd_t ly;
    } walk_pos_t;

    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int clamp_to(input int v, input int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int wrap_add(input int a, input int b, input int m);
        int s;
        s = a + b;
        return (s >= m) ? s - m : s;
    endfunction

endpackage

// File: rtl/swin_walk.sv
module swin_walk
    import swin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  span_t     col_span,
    input  span_t     row_span,
    input  logic      two_banks,
    input  logic      step,
    output logic      busy,
    output walk_pos_t pos,
    output logic      at_end
);

    span_t col_q, row_q;
    logic  two_q;

    assign at_end = busy && (pos.lx == col_q.last) && (pos.ly == row_q.last)
                    && (pos.bank == two_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pos   <= '0;
            col_q <= '0;
            row_q <= '0;
            two_q <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            pos   <= '{bank: 1'b0, lx: col_span.first, ly: row_span.first};
            col_q <= col_span;
            row_q <= row_span;
            two_q <= two_banks;
        end else if (busy && step) begin
            if (at_end) begin
                busy <= 1'b0;
            end else if (pos.lx != col_q.last) begin
                pos.lx <= pos.lx + crd_t'(1);
            end else begin
                pos.lx <= col_q.first;
                if (pos.ly != row_q.last) begin
                    pos.ly <= pos.ly + crd_t'(1);
                end else begin
                    pos.ly   <= row_q.first;
                    pos.bank <= 1'b1;
                end
            end
        end
    end

    AST_WALK_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pos.lx >= col_q.first) && (pos.lx <= col_q.last)
                 && (pos.ly >= row_q.first) && (pos.ly <= row_q.last)); // R2

endmodule

// File: rtl/swin_addr_map.sv
module swin_addr_map
    import swin_pkg::*;
#(
    parameter int MB_SIZE = 16,
    parameter int WIN_W   = 80,
    parameter int WIN_H   = 48,
    parameter int BAND_W  = 416,
    parameter int BANK_SZ = 3840,
    parameter int ADDR_W  = 15
) (
    input  logic              lowpwr,
    input  logic              bank,
    input  crd_t              lx,
    input  crd_t              ly,
    input  crd_t              base,
    input  crd_t              mbc,
    input  crd_t              mbr,
    output logic [ADDR_W-1:0] addr
);

    int pcol, prow, lin;

    always_comb begin
        pcol = 0;
        prow = 0;
        if (lowpwr) begin
            prow = (int'(mbr) * MB_SIZE + int'(ly)) % WIN_H;
            lin  = prow * BAND_W + int'(mbc) * MB_SIZE + int'(lx);
        end else begin
            pcol = wrap_add(int'(lx), int'(base), WIN_W);
            lin  = int'(bank) * BANK_SZ + int'(ly) * WIN_W + pcol;
        end
        addr = ADDR_W'(lin);
    end

endmodule

// File: rtl/swin_ctrl.sv
module swin_ctrl
    import swin_pkg::*;
#(
    parameter int MB_SIZE     = 16,
    parameter int SR_H        = 32,
    parameter int SR_V        = 16,
    parameter int FRAME_MBS_W = 22,
    parameter int FRAME_MBS_H = 18,
    parameter int PIX_W       = 8,
    localparam int WIN_W   = 2 * SR_H + MB_SIZE,
    localparam int WIN_H   = 2 * SR_V + MB_SIZE,
    localparam int FRM_W   = FRAME_MBS_W * MB_SIZE,
    localparam int FRM_H   = FRAME_MBS_H * MB_SIZE,
    localparam int BAND_W  = FRM_W + 2 * SR_H,
    localparam int BANK_SZ = WIN_W * WIN_H,
    localparam int SPACE   = (2 * BANK_SZ > BAND_W * WIN_H) ? 2 * BANK_SZ : BAND_W * WIN_H,
    localparam int ADDR_W  = bits_for(SPACE),
    localparam int MBC_W   = bits_for(FRAME_MBS_W),
    localparam int MBR_W   = bits_for(FRAME_MBS_H),
    localparam int FX_W    = bits_for(FRM_W),
    localparam int FY_W    = bits_for(FRM_H),
    localparam int WX_W    = bits_for(WIN_W),
    localparam int WY_W    = bits_for(WIN_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_lp,
    input  logic              mb_start,
    input  logic [MBC_W-1:0]  mb_col,
    input  logic [MBR_W-1:0]  mb_row,
    output logic              win_ready,
    output logic              req_vld,
    input  logic              req_rdy,
    output logic              req_ref,
    output logic [FX_W-1:0]   req_x,
    output logic [FY_W-1:0]   req_y,
    input  logic              rsp_vld,
    input  logic [PIX_W-1:0]  rsp_pix,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic              rd_ref,
    input  logic [WX_W-1:0]   rd_x,
    input  logic [WY_W-1:0]   rd_y,
    output logic              rd_vld,
    output logic [ADDR_W-1:0] rd_addr
);

    logic      mode_q, ready_q;
    crd_t      mbc_q, mbr_q, base_q;
    walk_pos_t req_pos, wr_pos;
    logic      req_busy, wr_busy, req_end, wr_end;
    logic      loading, accept;
    span_t     col_span, row_span;
    logic [ADDR_W-1:0] rd_map_addr;

    assign loading = req_busy || wr_busy;
    assign accept  = mb_start && !loading;

    always_comb begin
        col_span.first = (mb_col == '0) ? '0 : crd_t'(WIN_W - MB_SIZE);
        col_span.last  = crd_t'(WIN_W - 1);
        row_span.first = (mode_lp && mb_row != '0) ? crd_t'(WIN_H - MB_SIZE) : '0;
        row_span.last  = crd_t'(WIN_H - 1);
    end

    swin_walk u_req_walk (
        .clk(clk), .rst(rst), .start(accept),
        .col_span(col_span), .row_span(row_span), .two_banks(!mode_lp),
        .step(req_vld && req_rdy),
        .busy(req_busy), .pos(req_pos), .at_end(req_end)
    );

    swin_walk u_wr_walk (
        .clk(clk), .rst(rst), .start(accept),
        .col_span(col_span), .row_span(row_span), .two_banks(!mode_lp),
        .step(wr_en),
        .busy(wr_busy), .pos(wr_pos), .at_end(wr_end)
    );

    assign req_vld = req_busy;
    assign req_ref = req_pos.bank;
    assign req_x   = FX_W'(clamp_to(int'(mbc_q) * MB_SIZE - SR_H + int'(req_pos.lx), FRM_W - 1));
    assign req_y   = FY_W'(clamp_to(int'(mbr_q) * MB_SIZE - SR_V + int'(req_pos.ly), FRM_H - 1));

    assign wr_en   = rsp_vld && wr_busy;
    assign wr_data = rsp_pix;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            mbc_q   <= '0;
            mbr_q   <= '0;
            base_q  <= '0;
            ready_q <= 1'b0;
        end else if (accept) begin
            mode_q  <= mode_lp;
            mbc_q   <= crd_t'(mb_col);
            mbr_q   <= crd_t'(mb_row);
            base_q  <= (mb_col == '0) ? '0 : crd_t'(wrap_add(int'(base_q), MB_SIZE, WIN_W));
            ready_q <= 1'b0;
        end else if (wr_en && wr_end) begin
            ready_q <= 1'b1;
        end
    end

    assign win_ready = ready_q;

    swin_addr_map #(
        .MB_SIZE(MB_SIZE), .WIN_W(WIN_W), .WIN_H(WIN_H),
        .BAND_W(BAND_W), .BANK_SZ(BANK_SZ), .ADDR_W(ADDR_W)
    ) u_wr_map (
        .lowpwr(mode_q), .bank(wr_pos.bank), .lx(wr_pos.lx), .ly(wr_pos.ly),
        .base(base_q), .mbc(mbc_q), .mbr(mbr_q), .addr(wr_addr)
    );

    swin_addr_map #(
        .MB_SIZE(MB_SIZE), .WIN_W(WIN_W), .WIN_H(WIN_H),
        .BAND_W(BAND_W), .BANK_SZ(BANK_SZ), .ADDR_W(ADDR_W)
    ) u_rd_map (
        .lowpwr(mode_q), .bank(rd_ref && !mode_q), .lx(crd_t'(rd_x)), .ly(crd_t'(rd_y)),
        .base(base_q), .mbc(mbc_q), .mbr(mbr_q), .addr(rd_map_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld  <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_vld  <= rd_en && ready_q;
            rd_addr <= rd_map_addr;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_vld && !req_rdy |=> req_vld && $stable(req_x) && $stable(req_y) && $stable(req_ref)); // R4

    AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        req_vld |-> (int'(req_x) < FRM_W) && (int'(req_y) < FRM_H)); // R3

    AST_LP_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        req_vld && mode_q |-> !req_ref); // R6

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        win_ready |-> !req_vld && !wr_en); // R7

    AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> int'(wr_addr) < SPACE); // R5

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        mb_start && loading |=> $stable(mbc_q) && $stable(mbr_q) && $stable(mode_q)); // R10

endmodule

// File: tb/swin_ctrl_bench.sv
module swin_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MB  = 4;
    localparam int SRH = 8;
    localparam int SRV = 4;
    localparam int FMW = 3;
    localparam int FMH = 3;
    localparam int PW  = 8;
    localparam int WW  = 2 * SRH + MB;
    localparam int WH  = 2 * SRV + MB;
    localparam int FW  = FMW * MB;
    localparam int FH  = FMH * MB;
    localparam int BW  = FW + 2 * SRH;
    localparam int BK  = WW * WH;
    localparam int SP  = (2 * BK > BW * WH) ? 2 * BK : BW * WH;
    localparam int AW  = swin_pkg::bits_for(SP);
    localparam int MCW = swin_pkg::bits_for(FMW);
    localparam int MRW = swin_pkg::bits_for(FMH);
    localparam int XW  = swin_pkg::bits_for(FW);
    localparam int YW  = swin_pkg::bits_for(FH);
    localparam int WXW = swin_pkg::bits_for(WW);
    localparam int WYW = swin_pkg::bits_for(WH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_lp = 1'b0, mb_start = 1'b0;
    logic [MCW-1:0] mb_col = '0;
    logic [MRW-1:0] mb_row = '0;
    logic win_ready, req_vld, req_ref, wr_en, rd_vld;
    logic req_rdy = 1'b0, rsp_vld = 1'b0, rd_en = 1'b0, rd_ref = 1'b0;
    logic [XW-1:0] req_x;
    logic [YW-1:0] req_y;
    logic [PW-1:0] rsp_pix = '0, wr_data;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [WXW-1:0] rd_x = '0;
    logic [WYW-1:0] rd_y = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swin_ctrl #(
        .MB_SIZE(MB), .SR_H(SRH), .SR_V(SRV),
        .FRAME_MBS_W(FMW), .FRAME_MBS_H(FMH), .PIX_W(PW)
    ) u_swin_ctrl (
        .clk(clk), .rst(rst), .mode_lp(mode_lp), .mb_start(mb_start),
        .mb_col(mb_col), .mb_row(mb_row), .win_ready(win_ready),
        .req_vld(req_vld), .req_rdy(req_rdy), .req_ref(req_ref),
        .req_x(req_x), .req_y(req_y), .rsp_vld(rsp_vld), .rsp_pix(rsp_pix),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_ref(rd_ref), .rd_x(rd_x), .rd_y(rd_y),
        .rd_vld(rd_vld), .rd_addr(rd_addr)
    );

    typedef struct {
        int rf;
        int x;
        int y;
        int addr;
        int pix;
    } exp_t;

    exp_t exp_req[$];
    exp_t exp_wr[$];
    int   rsp_q[$];
    int   shadow [SP];
    int   n_checks = 0;
    int   n_errs = 0;
    bit   ready_due = 1'b0;
    bit   inject_idle = 1'b0;
    bit   done = 1'b0;

    function automatic int pix_of(int rf, int x, int y);
        return (x * 7 + y * 13 + rf * 101 + 3) & 255;
    endfunction

    function automatic int clampi(int v, int hi);
        return (v < 0) ? 0 : ((v > hi) ? hi : v);
    endfunction

    function automatic int exp_addr(bit lp, int rf, int col, int row, int lx, int ly);
        if (lp) return ((row * MB + ly) % WH) * BW + col * MB + lx;
        return rf * BK + ly * WW + ((lx + col * MB) % WW);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic build_expect(int col, int row, bit lp);
        int c0, r0, nref;
        c0   = (col == 0) ? 0 : WW - MB;
        r0   = (lp && row > 0) ? WH - MB : 0;
        nref = lp ? 1 : 2;
        for (int rf = 0; rf < nref; rf++)
            for (int ly = r0; ly < WH; ly++)
                for (int lx = c0; lx < WW; lx++) begin
                    exp_t e;
                    e.rf   = rf;
                    e.x    = clampi(col * MB - SRH + lx, FW - 1);
                    e.y    = clampi(row * MB - SRV + ly, FH - 1);
                    e.addr = exp_addr(lp, rf, col, row, lx, ly);
                    e.pix  = pix_of(rf, e.x, e.y);
                    exp_req.push_back(e);
                    exp_wr.push_back(e);
                end
    endtask

    // external memory model: random acceptance, in-order responses
    initial begin
        void'($urandom(32'd2024));
        forever begin
            @(posedge clk);
            #2;
            req_rdy = ($urandom % 4) != 0;
            if (inject_idle) begin
                rsp_vld = 1'b1;
                rsp_pix = 8'hAA;
            end else if (rsp_q.size() > 0 && ($urandom % 3) != 0) begin
                rsp_vld = 1'b1;
                rsp_pix = PW'(rsp_q.pop_front());
            end else begin
                rsp_vld = 1'b0;
            end
        end
    end

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && !done) begin
                if (ready_due) begin
                    check(win_ready == 1'b1, "R7 ready after last write", int'(win_ready), 1);
                    ready_due = 1'b0;
                end
                if (inject_idle && win_ready)
                    check(wr_en == 1'b0, "R11 idle response ignored", int'(wr_en), 0);
                if (req_vld && req_rdy) begin
                    if (exp_req.size() == 0) begin
                        check(1'b0, "R2 unexpected request", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_req.pop_front();
                        check(int'(req_ref) == e.rf, "R2 request bank", int'(req_ref), e.rf);
                        check(int'(req_x) == e.x, "R3 request x", int'(req_x), e.x);
                        check(int'(req_y) == e.y, "R3 request y", int'(req_y), e.y);
                    end
                    rsp_q.push_back(pix_of(int'(req_ref), int'(req_x), int'(req_y)));
                end
                if (wr_en) begin
                    if (exp_wr.size() == 0) begin
                        check(1'b0, "R11 unexpected write", int'(wr_addr), -1);
                    end else begin
                        exp_t e;
                        e = exp_wr.pop_front();
                        check(int'(wr_addr) == e.addr, mode_lp ? "R6 write address" : "R5 write address",
                              int'(wr_addr), e.addr);
                        check(int'(wr_data) == e.pix, "R11 write data", int'(wr_data), e.pix);
                        shadow[e.addr] = e.pix;
                        if (exp_wr.size() == 0) ready_due = 1'b1;
                    end
                end
            end
        end
    end

    task automatic do_read(int x, int y, int rf, bit expect_vld, bit lp, int col, int row, string tag);
        int ea, fx, fy, erf;
        @(posedge clk);
        #1;
        rd_en  = 1'b1;
        rd_x   = WXW'(x);
        rd_y   = WYW'(y);
        rd_ref = rf[0];
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        @(negedge clk);
        check(rd_vld == expect_vld, tag, int'(rd_vld), int'(expect_vld));
        if (expect_vld) begin
            erf = lp ? 0 : rf;
            ea  = exp_addr(lp, erf, col, row, x, y);
            fx  = clampi(col * MB - SRH + x, FW - 1);
            fy  = clampi(row * MB - SRV + y, FH - 1);
            check(int'(rd_addr) == ea, tag, int'(rd_addr), ea);
            check(shadow[ea] == pix_of(erf, fx, fy), "R8 window content", shadow[ea], pix_of(erf, fx, fy));
        end
    endtask

    task automatic do_mb(int col, int row, bit lp);
        int t;
        build_expect(col, row, lp);
        @(posedge clk);
        #1;
        mb_start = 1'b1;
        mb_col   = MCW'(col);
        mb_row   = MRW'(row);
        mode_lp  = lp;
        @(posedge clk);
        #1;
        mb_start = 1'b0;
        @(negedge clk);
        check(win_ready == 1'b0, "R7 ready clears on start", int'(win_ready), 0);
        if (col == 1) begin
            // stray start during the load: R10
            @(posedge clk);
            #1;
            mb_start = 1'b1;
            mb_col   = MCW'((col + 1) % FMW);
            mode_lp  = !lp;
            @(posedge clk);
            #1;
            mb_start = 1'b0;
            mode_lp  = lp;
            do_read(3, 2, 0, 1'b0, lp, col, row, "R8 read stalled while loading");
        end
        t = 0;
        while (!win_ready && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(win_ready == 1'b1, "R7 load completes", int'(win_ready), 1);
        check(exp_wr.size() == 0, col == 1 ? "R10 stray start added nothing" : "R2 write count",
              exp_wr.size(), 0);
        check(exp_req.size() == 0, "R2 request count", exp_req.size(), 0);
        do_read(0, 0, 0, 1'b1, lp, col, row, "R8 read corner low");
        do_read(WW - 1, WH - 1, lp ? 0 : 1, 1'b1, lp, col, row, "R8 read corner high");
        for (int k = 0; k < 4; k++)
            do_read($urandom % WW, $urandom % WH, $urandom % 2, 1'b1, lp, col, row,
                    lp ? "R9 read ignores ref" : "R8 random read");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(win_ready == 1'b0, "R1 reset ready", int'(win_ready), 0);
        check(req_vld == 1'b0, "R1 reset req", int'(req_vld), 0);
        check(wr_en == 1'b0, "R1 reset wr", int'(wr_en), 0);
        check(rd_vld == 1'b0, "R1 reset rd", int'(rd_vld), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(win_ready == 1'b0 && req_vld == 1'b0, "R1 after reset", int'(win_ready), 0);
        do_read(1, 1, 0, 1'b0, 1'b0, 0, 0, "R8 read before any load");
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < FMH; r++)
                for (int c = 0; c < FMW; c++) begin
                    do_mb(c, r, m[0]);
                    if (c == 2 && r == 0) begin
                        @(posedge clk);
                        #1;
                        inject_idle = 1'b1;
                        repeat (3) @(posedge clk);
                        #1;
                        inject_idle = 1'b0;
                        @(negedge clk);
                        check(win_ready == 1'b1, "R11 ready kept after idle beat", int'(win_ready), 1);
                    end
                end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule